// File: doc/BRIEF.md
# Acknowledged Packet Sender with Timed Retransmission

This block is the transmit end of an end-to-end reliable transport. It takes a message as a stream of words, cuts it into packets of a fixed number of words, labels every packet with a sequence number and a final-packet flag, and presents each packet as one wide beat on an output stream. Each packet is kept in one of four holding buffers until the far end returns an acknowledgment that carries the same sequence number. Loss is never signalled directly. A packet whose acknowledgment does not come back within a programmable number of cycles is offered again. Each resend restarts the timer.

Software or an upstream engine writes one message at a time. The block reports completion with a one-cycle pulse. It keeps a count of the resends made for the current message. If any packet times out once more after it has already been resent the configured maximum number of times, the block gives up on the message and raises a sticky error flag.

Top module: `ack_retx_sender`

## Requirements
- R1: After reset pkt_valid, done and error are low, retry_cnt is zero and msg_ready is high.
- R2: Words are grouped PKT_WORDS to a packet in arrival order. Word k of a packet sits in pkt_payload bits [k*DATA_W +: DATA_W]. A short final packet has its unused upper words set to zero. pkt_last is high only on the packet that holds the message's last word.
- R3: The first packet of each message carries sequence number 0. Each further packet carries the previous number plus one, modulo 2^SEQ_W.
- R4: Packet n of a message is held in buffer n mod 4. msg_ready is low while that buffer still holds an unacknowledged packet. It is also low from the acceptance of the message's last word until done or error.
- R5: pkt_valid is high whenever any held packet awaits (re)transmission. When several wait, the one with the smallest sequence number modulo 4 is offered. Once offered with pkt_ready low, the same packet stays on the port until taken.
- R6: An ack_valid beat whose ack_seq equals the number of a packet that has been transmitted and awaits acknowledgment releases that packet's buffer. An acknowledgment sampled up to and including cfg_timeout clock edges after the transmit handshake edge counts.
- R7: An acknowledgment whose number matches no packet awaiting acknowledgment (unknown, or already acknowledged) changes nothing.
- R8: Without an acknowledgment, a transmitted packet is offered again starting exactly cfg_timeout clock edges after its handshake edge. The timer restarts on every resend.
- R9: retry_cnt counts the resends of the current message. It saturates at its maximum and returns to zero when the first word of the next message is accepted.
- R10: If a packet that has already been resent cfg_max_retry times times out again, all held packets are dropped and error goes high. Any remaining words of that message are accepted and discarded up to msg_last. error falls when the first word of the next message is accepted.
- R11: done is high for exactly one cycle. It rises one clock after the edge at which the last outstanding packet of a fully accepted message was acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timeout | input | TMO_W | Acknowledgment wait in cycles |
| cfg_max_retry | input | RTY_W | Resends allowed per packet |
| msg_valid | input | 1 | Message word present |
| msg_ready | output | 1 | Message word accepted this cycle |
| msg_data | input | DATA_W | Message word |
| msg_last | input | 1 | Last word of the message |
| pkt_valid | output | 1 | Packet offered |
| pkt_ready | input | 1 | Downstream takes the packet |
| pkt_seq | output | SEQ_W | Packet sequence number |
| pkt_last | output | 1 | Final packet of the message |
| pkt_payload | output | PKT_WORDS*DATA_W | Packet body, word 0 lowest |
| ack_valid | input | 1 | Acknowledgment present |
| ack_seq | input | SEQ_W | Acknowledged sequence number |
| done | output | 1 | Message completed pulse |
| error | output | 1 | Message aborted, sticky |
| retry_cnt | output | RCNT_W | Resends in current message |

## Verification
The hardest state to reach is an abort that lands while the message is still only partly accepted. For that, all four buffers must be full, the input must be stalled on the buffer of the oldest packet, and that packet must run out its resends. The bench suppresses every acknowledgment, lowers the retry limit and sends a message of six packets. The window then fills, the oldest packet times out twice, and the rest of the message has to be drained. The next message then shows that error clears. Out-of-order and stale acknowledgments come from a responder whose delay depends on sequence parity, plus injected acknowledgments for numbers that are not outstanding.

// File: rtl/ars_pkg.sv
// Package: shared types of the acknowledged packet sender.
// Assumes: nothing beyond IEEE 1800-2017.
package ars_pkg;
    // Life cycle of one holding buffer.
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_SEND = 2'd1,
        SLOT_WAIT = 2'd2
    } slot_st_t;
endpackage

// File: rtl/ars_slot.sv
// Module: one holding buffer of the sender window.
// Collects the words of one packet, waits for its turn on the output,
// then times the acknowledgment and asks for a resend or an abort.
// Assumes: wr_en only arrives while the buffer is free; flush has priority.
module ars_slot
    import ars_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PKT_W  = 32,
    parameter int CNT_W  = 2,
    parameter int SEQ_W  = 4,
    parameter int TMO_W  = 16,
    parameter int RTY_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic             wr_close,
    input  logic             wr_last,
    input  logic [SEQ_W-1:0] wr_seq,
    input  logic             sent,
    input  logic             ack_valid,
    input  logic [SEQ_W-1:0] ack_seq,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic [RTY_W-1:0] cfg_max_retry,
    output logic             is_free,
    output logic             is_send,
    output logic [SEQ_W-1:0] seq_q,
    output logic             last_q,
    output logic [PKT_W-1:0] payload_q,
    output logic             retry_ev,
    output logic             abort_ev
);
    slot_st_t         state;
    logic [TMO_W-1:0] timer;
    logic [RTY_W-1:0] tries;
    logic             ack_hit;
    logic             expired;
    logic [TMO_W:0]   timer_inc;

    // Decode acknowledgment match and timer expiry for the waiting state.
    always_comb begin
        timer_inc = {1'b0, timer} + {{TMO_W{1'b0}}, 1'b1};
        ack_hit   = (state == SLOT_WAIT) && ack_valid && (ack_seq == seq_q);
        expired   = (state == SLOT_WAIT) && !ack_hit && (timer_inc >= {1'b0, cfg_timeout});
        retry_ev  = expired && (tries != cfg_max_retry);
        abort_ev  = expired && (tries == cfg_max_retry);
        is_free   = (state == SLOT_FREE);
        is_send   = (state == SLOT_SEND);
    end

    // Buffer state machine: fill, offer, wait, resend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SLOT_FREE;
            timer     <= '0;
            tries     <= '0;
            seq_q     <= '0;
            last_q    <= 1'b0;
            payload_q <= '0;
        end else if (flush) begin
            state <= SLOT_FREE;
        end else begin
            case (state)
                SLOT_FREE: begin
                    if (wr_en) begin
                        if (wr_idx == '0) begin
                            payload_q <= PKT_W'(wr_data);
                        end else begin
                            payload_q[wr_idx*DATA_W +: DATA_W] <= wr_data;
                        end
                        if (wr_close) begin
                            state  <= SLOT_SEND;
                            seq_q  <= wr_seq;
                            last_q <= wr_last;
                            tries  <= '0;
                        end
                    end
                end
                SLOT_SEND: begin
                    if (sent) begin
                        state <= SLOT_WAIT;
                        timer <= '0;
                    end
                end
                SLOT_WAIT: begin
                    if (ack_hit) begin
                        state <= SLOT_FREE;
                    end else if (expired) begin
                        if (tries != cfg_max_retry) begin
                            state <= SLOT_SEND;
                            tries <= tries + 1'b1;
                        end
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: state <= SLOT_FREE;
            endcase
        end
    end
endmodule

// File: rtl/ars_arb.sv
// Module: output selector of the sender window.
// Offers the lowest-numbered buffer that wants to transmit and keeps a
// stalled offer on the port until it is taken.
// Assumes: send_vec bits only fall through a handshake or a flush.
module ars_arb #(
    parameter int WIN   = 4,
    parameter int WIN_W = 2,
    parameter int SEQ_W = 4,
    parameter int PKT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [WIN-1:0]             send_vec,
    input  logic [WIN-1:0][SEQ_W-1:0]  seq_vec,
    input  logic [WIN-1:0]             last_vec,
    input  logic [WIN-1:0][PKT_W-1:0]  pay_vec,
    input  logic                       pkt_ready,
    output logic                       pkt_valid,
    output logic [SEQ_W-1:0]           pkt_seq,
    output logic                       pkt_last,
    output logic [PKT_W-1:0]           pkt_payload,
    output logic [WIN-1:0]             sent_vec
);
    logic             hold_v;
    logic [WIN_W-1:0] hold_idx;
    logic [WIN_W-1:0] sel;

    // Pick the held buffer if still waiting, else the lowest waiting one.
    always_comb begin
        sel = '0;
        for (int i = WIN - 1; i >= 0; i--) begin
            if (send_vec[i]) sel = WIN_W'(i);
        end
        if (hold_v && send_vec[hold_idx]) sel = hold_idx;
        pkt_valid   = |send_vec;
        pkt_seq     = seq_vec[sel];
        pkt_last    = last_vec[sel];
        pkt_payload = pay_vec[sel];
        sent_vec    = '0;
        sent_vec[sel] = pkt_valid && pkt_ready;
    end

    // Remember a stalled offer so the port stays stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v   <= 1'b0;
            hold_idx <= '0;
        end else begin
            hold_v   <= pkt_valid && !pkt_ready && !flush;
            hold_idx <= sel;
        end
    end
endmodule

// File: rtl/ack_retx_sender.sv
// Module: acknowledged packet sender with timed retransmission (top).
// Splits a word stream into numbered packets, keeps up to WIN packets
// until acknowledged, resends on timeout and aborts after too many tries.
// Assumes: WIN is a power of two not above 2^SEQ_W; configuration is
// changed only between messages.
module ack_retx_sender
    import ars_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PKT_WORDS = 4,
    parameter int SEQ_W     = 4,
    parameter int WIN       = 4,
    parameter int TMO_W     = 16,
    parameter int RTY_W     = 4,
    parameter int RCNT_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [TMO_W-1:0]              cfg_timeout,
    input  logic [RTY_W-1:0]              cfg_max_retry,
    input  logic                          msg_valid,
    output logic                          msg_ready,
    input  logic [DATA_W-1:0]             msg_data,
    input  logic                          msg_last,
    output logic                          pkt_valid,
    input  logic                          pkt_ready,
    output logic [SEQ_W-1:0]              pkt_seq,
    output logic                          pkt_last,
    output logic [PKT_WORDS*DATA_W-1:0]   pkt_payload,
    input  logic                          ack_valid,
    input  logic [SEQ_W-1:0]              ack_seq,
    output logic                          done,
    output logic                          error,
    output logic [RCNT_W-1:0]             retry_cnt
);
    localparam int PKT_W = PKT_WORDS * DATA_W;
    localparam int CNT_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;
    localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;

    logic [SEQ_W-1:0]            nseq;
    logic [CNT_W-1:0]            wcnt;
    logic                        closed, drain, in_msg, err_q, done_q;
    logic [RCNT_W-1:0]           rcnt;
    logic [WIN_W-1:0]            wslot;
    logic                        acc, wr_on, close_pkt, abort, all_free, done_n;
    logic [WIN-1:0]              slot_free, slot_send, slot_retry, slot_abort, sent_vec;
    logic [WIN-1:0][SEQ_W-1:0]   slot_seq;
    logic [WIN-1:0]              slot_last;
    logic [WIN-1:0][PKT_W-1:0]   slot_pay;
    logic [WIN_W:0]              nret;
    logic [RCNT_W:0]             rsum;

    // Input acceptance, packet closing and window status.
    always_comb begin
        wslot     = nseq[WIN_W-1:0];
        msg_ready = drain || (!closed && slot_free[wslot]);
        acc       = msg_valid && msg_ready;
        wr_on     = acc && !drain;
        close_pkt = wr_on && (msg_last || (wcnt == CNT_W'(PKT_WORDS - 1)));
        abort     = |slot_abort;
        all_free  = &slot_free;
        done_n    = closed && all_free;
        nret      = '0;
        for (int i = 0; i < WIN; i++) nret = nret + (WIN_W + 1)'(slot_retry[i]);
        rsum      = {1'b0, rcnt} + (RCNT_W + 1)'(nret);
    end

    for (genvar g = 0; g < WIN; g++) begin : g_slot
        ars_slot #(
            .DATA_W(DATA_W), .PKT_W(PKT_W), .CNT_W(CNT_W),
            .SEQ_W(SEQ_W), .TMO_W(TMO_W), .RTY_W(RTY_W)
        ) slot_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .flush        (abort),
            .wr_en        (wr_on && (wslot == WIN_W'(g))),
            .wr_idx       (wcnt),
            .wr_data      (msg_data),
            .wr_close     (close_pkt),
            .wr_last      (msg_last),
            .wr_seq       (nseq),
            .sent         (sent_vec[g]),
            .ack_valid    (ack_valid),
            .ack_seq      (ack_seq),
            .cfg_timeout  (cfg_timeout),
            .cfg_max_retry(cfg_max_retry),
            .is_free      (slot_free[g]),
            .is_send      (slot_send[g]),
            .seq_q        (slot_seq[g]),
            .last_q       (slot_last[g]),
            .payload_q    (slot_pay[g]),
            .retry_ev     (slot_retry[g]),
            .abort_ev     (slot_abort[g])
        );
    end

    ars_arb #(
        .WIN(WIN), .WIN_W(WIN_W), .SEQ_W(SEQ_W), .PKT_W(PKT_W)
    ) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (abort),
        .send_vec   (slot_send),
        .seq_vec    (slot_seq),
        .last_vec   (slot_last),
        .pay_vec    (slot_pay),
        .pkt_ready  (pkt_ready),
        .pkt_valid  (pkt_valid),
        .pkt_seq    (pkt_seq),
        .pkt_last   (pkt_last),
        .pkt_payload(pkt_payload),
        .sent_vec   (sent_vec)
    );

    // Message-level control: numbering, word count, completion and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nseq   <= '0;
            wcnt   <= '0;
            closed <= 1'b0;
            drain  <= 1'b0;
            in_msg <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            rcnt   <= '0;
        end else begin
            done_q <= done_n;
            if (acc && !in_msg) begin
                rcnt  <= '0;
                err_q <= 1'b0;
            end else if (!abort) begin
                rcnt <= rsum[RCNT_W] ? {RCNT_W{1'b1}} : rsum[RCNT_W-1:0];
            end
            if (acc) in_msg <= !msg_last;
            if (acc && msg_last) begin
                if (drain) drain <= 1'b0;
                else       closed <= 1'b1;
            end
            if (wr_on) begin
                if (close_pkt) begin
                    nseq <= nseq + 1'b1;
                    wcnt <= '0;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
            end
            if (done_n) begin
                closed <= 1'b0;
                nseq   <= '0;
            end
            if (abort) begin
                err_q  <= 1'b1;
                closed <= 1'b0;
                wcnt   <= '0;
                nseq   <= '0;
                drain  <= acc ? !msg_last : in_msg;
            end
        end
    end

    assign done      = done_q;
    assign error     = err_q;
    assign retry_cnt = rcnt;
endmodule

// File: rtl/ack_retx_sender_chk.sv
// Module: protocol checker for the acknowledged packet sender.
// Watches the top-level ports only; attached by the bind below.
// Assumes: synchronous active-low reset on rst_n.
module ack_retx_sender_chk #(
    parameter int SEQ_W  = 4,
    parameter int PKT_W  = 32,
    parameter int RCNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_ready,
    input logic              pkt_valid,
    input logic              pkt_ready,
    input logic [SEQ_W-1:0]  pkt_seq,
    input logic              pkt_last,
    input logic [PKT_W-1:0]  pkt_payload,
    input logic              done,
    input logic              error,
    input logic [RCNT_W-1:0] retry_cnt
);
    // R5: a stalled offer stays unchanged until taken or aborted.
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=>
            (pkt_valid && $stable(pkt_seq) && $stable(pkt_last) && $stable(pkt_payload)) || $rose(error));

    // R11: completion is a single-cycle pulse.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: input was closed in the cycle before completion.
    p_closed_before_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(msg_ready));

    // R10: an aborted message offers nothing and never completes.
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!pkt_valid && !done));

    // R9: the resend count only grows, or restarts at zero.
    p_retry_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt != $past(retry_cnt)) |-> ((retry_cnt > $past(retry_cnt)) || (retry_cnt == '0)));
endmodule

bind ack_retx_sender ack_retx_sender_chk #(
    .SEQ_W (SEQ_W),
    .PKT_W (PKT_WORDS * DATA_W),
    .RCNT_W(RCNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_ready  (msg_ready),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_seq    (pkt_seq),
    .pkt_last   (pkt_last),
    .pkt_payload(pkt_payload),
    .done       (done),
    .error      (error),
    .retry_cnt  (retry_cnt)
);

// File: tb/ack_retx_sender_tb_top.sv
// Bench: behavioural reference model compared with the design every cycle,
// plus an acknowledgment responder and directed message scenarios.
module ack_retx_sender_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_timeout = 16'd12;
    logic [3:0]  cfg_max_retry = 4'd2;
    logic        msg_valid = 1'b0;
    logic        msg_ready;
    logic [7:0]  msg_data = 8'h00;
    logic        msg_last = 1'b0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b1;
    logic [3:0]  pkt_seq;
    logic        pkt_last;
    logic [31:0] pkt_payload;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_seq = 4'd0;
    logic        done;
    logic        error;
    logic [7:0]  retry_cnt;

    ack_retx_sender dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout), .cfg_max_retry(cfg_max_retry),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data), .msg_last(msg_last),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_seq(pkt_seq), .pkt_last(pkt_last),
        .pkt_payload(pkt_payload), .ack_valid(ack_valid), .ack_seq(ack_seq),
        .done(done), .error(error), .retry_cnt(retry_cnt)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_st[4];
    int          m_sq[4];
    bit          m_lst[4];
    logic [31:0] m_pay[4];
    int          m_tmr[4];
    int          m_try[4];
    int          m_nseq, m_wcnt, m_rcnt, m_holdi;
    bit          m_closed, m_drain, m_inmsg, m_err, m_done, m_holdv;

    function automatic int m_sel();
        if (m_holdv && m_st[m_holdi] == 1) return m_holdi;
        for (int i = 0; i < 4; i++) if (m_st[i] == 1) return i;
        return -1;
    endfunction

    function automatic bit m_ready();
        return m_drain || (!m_closed && m_st[m_nseq % 4] == 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_st[i] = 0; m_sq[i] = 0; m_lst[i] = 0; m_pay[i] = 0; m_tmr[i] = 0; m_try[i] = 0;
            end
            m_nseq = 0; m_wcnt = 0; m_rcnt = 0; m_holdi = 0;
            m_closed = 0; m_drain = 0; m_inmsg = 0; m_err = 0; m_done = 0; m_holdv = 0;
        end else begin
            int sel, nret, tmo;
            bit rdy, abort, allfree, done_n;
            int nst[4];
            sel = m_sel();
            rdy = m_ready();
            tmo = int'(cfg_timeout);
            abort = 0; nret = 0; allfree = 1;
            for (int i = 0; i < 4; i++) begin
                nst[i] = m_st[i];
                if (m_st[i] != 0) allfree = 0;
            end
            done_n = m_closed && allfree;
            for (int i = 0; i < 4; i++) begin
                if (m_st[i] == 2) begin
                    if (ack_valid && int'(ack_seq) == m_sq[i]) nst[i] = 0;
                    else if (m_tmr[i] + 1 >= tmo) begin
                        if (m_try[i] == int'(cfg_max_retry)) abort = 1;
                        else begin nst[i] = 1; m_try[i]++; nret++; end
                    end else m_tmr[i]++;
                end
            end
            if (sel >= 0 && pkt_ready) begin nst[sel] = 2; m_tmr[sel] = 0; end
            m_holdv = (sel >= 0) && !pkt_ready;
            m_holdi = (sel >= 0) ? sel : 0;
            if (msg_valid && rdy && !m_inmsg) begin m_err = 0; m_rcnt = 0; end
            else if (!abort) m_rcnt = (m_rcnt + nret > 255) ? 255 : m_rcnt + nret;
            if (msg_valid && rdy) begin
                if (m_drain) begin
                    if (msg_last) begin m_drain = 0; m_inmsg = 0; end
                end else begin
                    int w;
                    w = m_nseq % 4;
                    m_inmsg = !msg_last;
                    if (m_wcnt == 0) m_pay[w] = {24'h0, msg_data};
                    else m_pay[w][m_wcnt*8 +: 8] = msg_data;
                    if (m_wcnt == 3 || msg_last) begin
                        nst[w] = 1; m_sq[w] = m_nseq % 16; m_lst[w] = msg_last; m_try[w] = 0;
                        m_nseq++; m_wcnt = 0;
                    end else m_wcnt++;
                    if (msg_last) m_closed = 1;
                end
            end
            if (done_n) begin m_closed = 0; m_nseq = 0; end
            if (abort) begin
                for (int i = 0; i < 4; i++) nst[i] = 0;
                m_err = 1; m_closed = 0; m_wcnt = 0; m_nseq = 0;
                m_drain = m_inmsg; m_holdv = 0;
            end
            m_done = done_n;
            for (int i = 0; i < 4; i++) m_st[i] = nst[i];
        end
    end

    // ---------------- responder and per-cycle comparison ----------------
    int cyc = 0;
    int rdy_mode = 0;
    int dly_even = 3, dly_odd = 3;
    int drop_once_seq = -1;
    bit dropped = 0;
    bit drop_all = 0;
    bit bogus_req = 0;
    logic [3:0] bogus_seq = 0;
    int due_q[$];
    int sq_q[$];
    int done_cnt = 0;
    int last_seq = -1;
    logic [31:0] last_pay = 0;
    bit saw_stall = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int s;
            s = m_sel();
            chk(msg_ready == m_ready(), "R4 msg_ready", msg_ready, m_ready());
            chk(pkt_valid == (s >= 0), "R5 pkt_valid", pkt_valid, s >= 0);
            if (s >= 0 && pkt_valid) begin
                chk(pkt_seq == 4'(m_sq[s]), "R3 pkt_seq", pkt_seq, m_sq[s]);
                chk(pkt_last == m_lst[s], "R2 pkt_last", pkt_last, m_lst[s]);
                chk(pkt_payload == m_pay[s], "R2 pkt_payload", pkt_payload, m_pay[s]);
            end
            chk(done == m_done, "R11 done", done, m_done);
            chk(error == m_err, "R10 error", error, m_err);
            chk(int'(retry_cnt) == m_rcnt, "R9 retry_cnt", retry_cnt, m_rcnt);
            if (done) done_cnt++;
            if (msg_valid && !msg_ready) saw_stall = 1;
        end
        cyc++;
        pkt_ready = (rdy_mode == 0) || (cyc % 3 != 0);
        if (rst_n && pkt_valid && pkt_ready) begin
            int sq;
            sq = int'(pkt_seq);
            if (pkt_last) begin last_seq = sq; last_pay = pkt_payload; end
            if (drop_all) begin end
            else if (sq == drop_once_seq && !dropped) dropped = 1;
            else begin
                due_q.push_back(cyc + ((sq % 2 == 0) ? dly_even : dly_odd));
                sq_q.push_back(sq);
            end
        end
        ack_valid = 1'b0;
        if (bogus_req) begin
            ack_valid = 1'b1; ack_seq = bogus_seq; bogus_req = 0;
        end else begin
            for (int i = 0; i < due_q.size(); i++) begin
                if (due_q[i] <= cyc) begin
                    ack_valid = 1'b1; ack_seq = 4'(sq_q[i]);
                    due_q.delete(i); sq_q.delete(i);
                    break;
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_msg(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            msg_valid = 1'b1; msg_data = base + 8'(i); msg_last = (i == n - 1);
            while (!msg_ready) @(negedge clk);
        end
        @(negedge clk);
        msg_valid = 1'b0; msg_last = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done || error) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!pkt_valid, "R1 pkt_valid", pkt_valid, 0);
        chk(msg_ready, "R1 msg_ready", msg_ready, 1);
        chk(!done && !error, "R1 done/error", {done, error}, 0);
        chk(retry_cnt == 0, "R1 retry_cnt", retry_cnt, 0);

        // R2 R3 R11: three packets, last one padded
        send_msg(10, 8'h10);
        wait_end(400);
        chk(done_cnt == 1, "R11 one done pulse", done_cnt, 1);
        chk(last_seq == 2, "R3 last seq", last_seq, 2);
        chk(last_pay == 32'h0000_1918, "R2 padded final packet", last_pay, 32'h0000_1918);

        // R8 R9: one lost acknowledgment
        drop_once_seq = 1; dropped = 0;
        send_msg(7, 8'h40);
        wait_end(600);
        chk(retry_cnt == 1, "R8 R9 one resend", retry_cnt, 1);
        chk(done_cnt == 2, "R11 done after resend", done_cnt, 2);
        drop_once_seq = -1;

        // R6 R7: out-of-order and stale or unknown acknowledgments
        dly_even = 10; dly_odd = 2;
        send_msg(8, 8'h60);
        repeat (4) @(posedge clk);
        bogus_seq = 4'd1; bogus_req = 1;
        @(posedge clk);
        @(posedge clk);
        bogus_seq = 4'd9; bogus_req = 1;
        wait_end(600);
        chk(retry_cnt == 0, "R7 ignored acks cause no resend", retry_cnt, 0);
        chk(done_cnt == 3, "R6 out-of-order acks complete", done_cnt, 3);

        // R3 R5: sequence wrap under backpressure
        dly_even = 5; dly_odd = 5; rdy_mode = 1;
        send_msg(72, 8'h00);
        wait_end(2000);
        chk(last_seq == 1, "R3 sequence wraps", last_seq, 1);
        chk(done_cnt == 4, "R5 done with backpressure", done_cnt, 4);
        rdy_mode = 0;

        // R4: full window stalls input
        cfg_timeout = 16'd40; dly_even = 30; dly_odd = 30; saw_stall = 0;
        send_msg(24, 8'h80);
        wait_end(2000);
        chk(saw_stall, "R4 window stall seen", saw_stall, 1);
        chk(done_cnt == 5, "R4 done after stall", done_cnt, 5);

        // R10: abort mid-message, drain, then recover
        cfg_timeout = 16'd12; cfg_max_retry = 4'd1; dly_even = 3; dly_odd = 3;
        drop_all = 1;
        send_msg(24, 8'hA0);
        repeat (3) @(negedge clk);
        chk(error, "R10 error after abort", error, 1);
        chk(!pkt_valid, "R10 nothing offered", pkt_valid, 0);
        chk(done_cnt == 5, "R10 no done on abort", done_cnt, 5);
        drop_all = 0; cfg_max_retry = 4'd2;
        send_msg(4, 8'hC0);
        chk(!error, "R10 error cleared by new message", error, 0);
        chk(retry_cnt == 0, "R9 count cleared", retry_cnt, 0);
        wait_end(400);
        chk(done_cnt == 6, "R10 recovery completes", done_cnt, 6);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule